// File: doc/BRIEF.md
# Windowed Watchdog Timer

A supervisory timer for a processor subsystem. A 12-bit down-counter steps once per enabled slow-clock tick (intended rate 256 Hz, so a full reload of 0xFFF spans roughly sixteen seconds). Software must restart it before it runs out. A restart that arrives too early is also treated as a failure. "Too early" means the counter is still above a programmable window threshold. Either failure latches a sticky status flag. It can raise an interrupt and can request a one-cycle system reset or a processor-only reset.

The configuration lives in a mode word that accepts exactly one write after reset. Later writes to it are discarded, so firmware that runs afterwards cannot loosen the supervision. Restarts are commands written to a control word and must carry a key byte. The counter can be frozen while the processor idles or is under debug, and the whole timer can be switched off by one mode bit.

Top module: `wdog_win_top`

## Requirements
- R1: Register map on `bus_addr`: 0 = control (write only, reads 0), 1 = mode, 2 = status, 3 reads 0. After reset the mode word reads 0x3FFF2FFF, the status reads 0 and all three request outputs are low.
- R2: Mode word layout: reload in bits 11:0, window threshold in bits 27:16, interrupt enable bit 12, reset enable bit 13, processor-only reset bit 14, disable bit 15, debug-halt bit 28, idle-halt bit 29; bits 31:30 read 0. Only the first mode write after reset is accepted and it also loads the counter with its reload field; later mode writes leave the mode word unchanged.
- R3: Each enabled tick lowers the counter by one. The tick that finds the counter at 1 or 0 is an underflow: it sets status bit 0 and loads the counter from the reload field, and counting continues. A reload of N therefore underflows on the Nth tick.
- R4: A control write restarts the counter (loads the reload field) only when bits 31:24 equal 0xA5 and bit 0 is 1; any other control write has no effect.
- R5: A restart that arrives while the counter exceeds the threshold, with the threshold below the reload, is an error. It sets status bit 1 and leaves the counter unchanged.
- R6: When the threshold is greater than or equal to the reload, every keyed restart is accepted.
- R7: With reset enable set, each underflow or error drives a one-cycle pulse on `rst_req_o`, in the cycle after the fault. If processor-only is also set, the pulse goes to `cpu_rst_req_o` instead. With reset enable clear, neither pulses.
- R8: `irq_o` is high whenever interrupt enable is set and any status bit is set.
- R9: Status bits stay set until a read of the status address. That read returns the old value and clears the bits, but a fault in the same cycle still sets its bit.
- R10: With the disable bit set, the counter does not move, no fault occurs and restarts are ignored.
- R11: With idle-halt set, ticks are ignored while `idle_i` is high. With debug-halt set, ticks are ignored while `dbg_i` is high. A halt input whose bit is clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tick_en | input | 1 | Slow-clock tick enable, one cycle wide |
| idle_i | input | 1 | Processor idle indication |
| dbg_i | input | 1 | Processor debug-halt indication |
| rst_req_o | output | 1 | System reset request pulse |
| cpu_rst_req_o | output | 1 | Processor-only reset request pulse |
| irq_o | output | 1 | Fault interrupt, level |

## Verification
The counter is not visible on the bus. A wrong count therefore only shows up when an underflow arrives earlier or later than expected, or when a restart is wrongly judged early. These surface on the reset outputs one cycle after the faulty tick, and on the interrupt and status in the same cycle. The directed sequences place status reads exactly one tick before and at the expected underflow, and they put restarts on both sides of the window threshold. An off-by-one in the counter or the window compare then changes a read value at once. A behavioural model compared on every clock catches stray pulses, wrong reset routing and lost sticky bits in the cycle they occur.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W = 12;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;
  localparam int MODE_W = 30;
  localparam int B_RELOAD = 0;
  localparam int B_WIN = 16;
  localparam int B_IRQEN = 12;
  localparam int B_RSTEN = 13;
  localparam int B_PROC = 14;
  localparam int B_DIS = 15;
  localparam int B_DBGH = 28;
  localparam int B_IDLEH = 29;
  localparam int ST_UF = 0;
  localparam int ST_ERR = 1;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter logic [MODE_W-1:0] MODE_RST = 30'h3FFF2FFF,
  parameter logic [7:0] KEY = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              uf_evt,
  input  logic              err_evt,
  output logic [MODE_W-1:0] mode_o,
  output logic              mode_wr_o,
  output logic [CNT_W-1:0]  wr_reload_o,
  output logic              restart_o,
  output logic [1:0]        stat_o
);
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              lock_q, lock_d;
  logic [1:0]        stat_q, stat_d;
  logic              stat_rd;

  assign mode_wr_o   = bus_sel && bus_we && (bus_addr == A_MODE) && !lock_q;
  assign wr_reload_o = bus_wdata[B_RELOAD +: CNT_W];
  assign restart_o   = bus_sel && bus_we && (bus_addr == A_CTRL) &&
                       (bus_wdata[31:24] == KEY) && bus_wdata[0];
  assign stat_rd     = bus_sel && !bus_we && (bus_addr == A_STAT);

  always_comb begin
    mode_d = mode_q;
    lock_d = lock_q;
    if (mode_wr_o) begin
      mode_d = bus_wdata[MODE_W-1:0];
      lock_d = 1'b1;
    end
    stat_d = stat_rd ? 2'b00 : stat_q;
    if (uf_evt)  stat_d[ST_UF]  = 1'b1;
    if (err_evt) stat_d[ST_ERR] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      lock_q <= 1'b0;
      stat_q <= 2'b00;
    end else begin
      mode_q <= mode_d;
      lock_q <= lock_d;
      stat_q <= stat_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      case (bus_addr)
        A_MODE:  bus_rdata = {{(32-MODE_W){1'b0}}, mode_q};
        A_STAT:  bus_rdata = {30'd0, stat_q};
        default: bus_rdata = '0;
      endcase
    end
  end

  assign mode_o = mode_q;
  assign stat_o = stat_q;

  // R2: once locked the mode word never changes again
  a_r2_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_q) |-> $stable(mode_q));
  // R9: a set underflow flag survives until a status read
  a_r9_uf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_q[ST_UF]) && !$past(stat_rd)) |-> stat_q[ST_UF]);
  // R9: a set error flag survives until a status read
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_q[ST_ERR]) && !$past(stat_rd)) |-> stat_q[ST_ERR]);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             idle_i,
  input  logic             dbg_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [CNT_W-1:0] win_i,
  input  logic             dis_i,
  input  logic             idle_hlt_i,
  input  logic             dbg_hlt_i,
  input  logic             mode_wr_i,
  input  logic [CNT_W-1:0] wr_reload_i,
  input  logic             restart_i,
  output logic             uf_o,
  output logic             err_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             halted, step, early, rs_ok;

  assign halted = (idle_hlt_i && idle_i) || (dbg_hlt_i && dbg_i);
  assign step   = tick_en && !dis_i && !halted;
  assign early  = (cnt_q > win_i) && (win_i < reload_i);
  assign rs_ok  = restart_i && !dis_i;

  always_comb begin
    cnt_d = cnt_q;
    uf_o  = 1'b0;
    err_o = 1'b0;
    if (mode_wr_i) begin
      cnt_d = wr_reload_i;
    end else if (rs_ok) begin
      if (early) err_o = 1'b1;
      else       cnt_d = reload_i;
    end else if (step) begin
      if (cnt_q <= CNT_W'(1)) begin
        uf_o  = 1'b1;
        cnt_d = reload_i;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end

  // R3: counter never exceeds the programmed reload
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= reload_i);
  // R10: a disabled timer keeps its count
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dis_i) |-> $stable(cnt_q));
  // R11: a halted timer produces no underflow
  a_r11_no_uf_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !uf_o);
endmodule

// File: rtl/wdog_fault_out.sv
module wdog_fault_out (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uf_i,
  input  logic       err_i,
  input  logic       rst_en_i,
  input  logic       proc_i,
  input  logic       irq_en_i,
  input  logic [1:0] stat_i,
  output logic       rst_req_o,
  output logic       cpu_rst_req_o,
  output logic       irq_o
);
  logic fault, rq_d, cpu_d, rq_q, cpu_q;

  assign fault = uf_i || err_i;
  assign rq_d  = fault && rst_en_i && !proc_i;
  assign cpu_d = fault && rst_en_i && proc_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_q  <= 1'b0;
      cpu_q <= 1'b0;
    end else begin
      rq_q  <= rq_d;
      cpu_q <= cpu_d;
    end
  end

  assign rst_req_o     = rq_q;
  assign cpu_rst_req_o = cpu_q;
  assign irq_o         = irq_en_i && (stat_i != 2'b00);

  // R7: at most one reset target per pulse
  a_r7_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req_o && cpu_rst_req_o));
  // R7: a system reset pulse follows a fault with reset enabled
  a_r7_sys_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> $past(fault && rst_en_i && !proc_i));
  // R7: a processor reset pulse follows a fault with processor-only set
  a_r7_cpu_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_req_o |-> $past(fault && rst_en_i && proc_i));
endmodule

// File: rtl/wdog_win_top.sv
module wdog_win_top
  import wdog_pkg::*;
#(
  parameter logic [7:0] KEY = 8'hA5,
  parameter logic [MODE_W-1:0] MODE_RST = 30'h3FFF2FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        tick_en,
  input  logic        idle_i,
  input  logic        dbg_i,
  output logic        rst_req_o,
  output logic        cpu_rst_req_o,
  output logic        irq_o
);
  logic [MODE_W-1:0] mode;
  logic              mode_wr, restart, uf, err;
  logic [CNT_W-1:0]  wr_reload;
  logic [1:0]        stat;

  wdog_regs #(.MODE_RST(MODE_RST), .KEY(KEY)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .uf_evt(uf), .err_evt(err), .mode_o(mode), .mode_wr_o(mode_wr),
    .wr_reload_o(wr_reload), .restart_o(restart), .stat_o(stat)
  );

  wdog_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .idle_i(idle_i), .dbg_i(dbg_i),
    .reload_i(mode[B_RELOAD +: CNT_W]), .win_i(mode[B_WIN +: CNT_W]),
    .dis_i(mode[B_DIS]), .idle_hlt_i(mode[B_IDLEH]), .dbg_hlt_i(mode[B_DBGH]),
    .mode_wr_i(mode_wr), .wr_reload_i(wr_reload), .restart_i(restart),
    .uf_o(uf), .err_o(err)
  );

  wdog_fault_out u_out (
    .clk(clk), .rst_n(rst_n), .uf_i(uf), .err_i(err),
    .rst_en_i(mode[B_RSTEN]), .proc_i(mode[B_PROC]), .irq_en_i(mode[B_IRQEN]),
    .stat_i(stat), .rst_req_o(rst_req_o), .cpu_rst_req_o(cpu_rst_req_o),
    .irq_o(irq_o)
  );
endmodule

// File: tb/wdog_win_tb.sv
module wdog_win_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic tick_en = 1'b0, idle_i = 1'b0, dbg_i = 1'b0;
  logic rst_req_o, cpu_rst_req_o, irq_o;

  int checks = 0, errors = 0;
  int n_sys = 0, n_cpu = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdog_win_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .idle_i(idle_i), .dbg_i(dbg_i),
    .rst_req_o(rst_req_o), .cpu_rst_req_o(cpu_rst_req_o), .irq_o(irq_o)
  );

  // behavioural reference state
  longint m_mode;
  int  m_cnt;
  bit  m_lock, m_rq, m_cpu;
  bit [1:0] m_stat;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int fld(input longint v, input int lo, input int w);
    return int'((v >> lo) & ((64'd1 << w) - 1));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 64'h3FFF2FFF; m_cnt = 4095; m_lock = 0;
      m_stat = 0; m_rq = 0; m_cpu = 0;
    end else begin
      bit uf, er, halt;
      int rl, wn;
      uf = 0; er = 0;
      rl = fld(m_mode, 0, 12); wn = fld(m_mode, 16, 12);
      halt = (fld(m_mode, 29, 1) == 1 && idle_i) || (fld(m_mode, 28, 1) == 1 && dbg_i);
      if (bus_sel && bus_we && bus_addr == 2'd1 && !m_lock) begin
        m_cnt = fld(bus_wdata, 0, 12);
      end else if (bus_sel && bus_we && bus_addr == 2'd0 && bus_wdata[31:24] == 8'hA5
                   && bus_wdata[0] && fld(m_mode, 15, 1) == 0) begin
        if (m_cnt > wn && wn < rl) er = 1; else m_cnt = rl;
      end else if (tick_en && fld(m_mode, 15, 1) == 0 && !halt) begin
        if (m_cnt <= 1) begin uf = 1; m_cnt = rl; end else m_cnt = m_cnt - 1;
      end
      m_rq  = (uf || er) && fld(m_mode, 13, 1) == 1 && fld(m_mode, 14, 1) == 0;
      m_cpu = (uf || er) && fld(m_mode, 13, 1) == 1 && fld(m_mode, 14, 1) == 1;
      if (bus_sel && !bus_we && bus_addr == 2'd2) m_stat = 0;
      if (uf) m_stat[0] = 1;
      if (er) m_stat[1] = 1;
      if (bus_sel && bus_we && bus_addr == 2'd1 && !m_lock) begin
        m_mode = longint'(bus_wdata) & 64'h3FFFFFFF;
        m_lock = 1;
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #5;
    if (rst_n && !done) begin
      longint exp_rd;
      chk("R7 rst_req_o", rst_req_o, m_rq);
      chk("R7 cpu_rst_req_o", cpu_rst_req_o, m_cpu);
      chk("R8 irq_o", irq_o, fld(m_mode, 12, 1) == 1 && m_stat != 0);
      exp_rd = 0;
      if (bus_sel && !bus_we) begin
        if (bus_addr == 2'd1) exp_rd = m_mode;
        if (bus_addr == 2'd2) exp_rd = m_stat;
      end
      chk("R1 bus_rdata", bus_rdata, exp_rd);
      if (rst_req_o) n_sys++;
      if (cpu_rst_req_o) n_cpu++;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #5 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1;
    end
    @(negedge clk); tick_en = 0;
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    n_sys = 0; n_cpu = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    do_reset();
    // R1: reset state
    rd(2'd1, d); chk("R1 mode reset", d, 32'h3FFF2FFF);
    rd(2'd2, d); chk("R1 status reset", d, 0);
    rd(2'd0, d); chk("R1 ctrl reads 0", d, 0);
    chk("R1 outputs low", {rst_req_o, cpu_rst_req_o, irq_o}, 0);
    // R6: default window covers the reload, restarts always legal
    wr(2'd0, 32'hA5000001);
    rd(2'd2, d); chk("R6 restart legal", d, 0);

    // Scenario: reload 20, window 10, reset + irq enable
    do_reset();
    wr(2'd1, 32'h000A3014);
    wr(2'd1, 32'h00000001);
    rd(2'd1, d); chk("R2 second mode write ignored", d, 32'h000A3014);
    wr(2'd0, 32'hA5000001);           // counter 20 > 10: early
    @(negedge clk); #5 chk("R8 irq on error", irq_o, 1);
    rd(2'd2, d); chk("R5 early restart error", d, 2);
    rd(2'd2, d); chk("R9 cleared by read", d, 0);
    ticks(19);
    rd(2'd2, d); chk("R5 counter untouched by early restart", d, 0);
    ticks(1);
    rd(2'd2, d); chk("R3 underflow on 20th tick", d, 1);
    chk("R7 system pulses", n_sys, 2);
    ticks(10);                         // counter 10: legal
    wr(2'd0, 32'hA5000001);
    rd(2'd2, d); chk("R4 legal restart no error", d, 0);
    ticks(19);
    rd(2'd2, d); chk("R4 restart reloaded", d, 0);
    ticks(1);
    rd(2'd2, d); chk("R3 underflow after reload", d, 1);
    ticks(5);                          // counter 15
    wr(2'd0, 32'hA4000001);
    wr(2'd0, 32'hA5000000);
    ticks(14);
    rd(2'd2, d); chk("R4 bad key ignored", d, 0);
    ticks(1);
    rd(2'd2, d); chk("R4 count kept through bad key", d, 1);

    // Scenario: reload 5, window 7, processor-only reset, idle halt
    do_reset();
    wr(2'd1, 32'h20076005);
    ticks(2);
    wr(2'd0, 32'hA5000001);
    rd(2'd2, d); chk("R6 window above reload legal", d, 0);
    idle_i = 1;
    ticks(10);
    rd(2'd2, d); chk("R11 idle halt freezes", d, 0);
    idle_i = 0; dbg_i = 1;
    ticks(5);
    dbg_i = 0;
    rd(2'd2, d); chk("R11 debug without halt bit counts", d, 1);
    chk("R7 cpu pulse count", n_cpu, 1);
    chk("R7 no system pulse", n_sys, 0);
    chk("R8 irq disabled", irq_o, 0);

    // Scenario: disabled timer
    do_reset();
    wr(2'd1, 32'h0000A003);
    ticks(10);
    wr(2'd0, 32'hA5000001);
    rd(2'd2, d); chk("R10 disabled no fault", d, 0);
    chk("R10 no pulses", n_sys + n_cpu, 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule